// File: doc/BRIEF.md
# Frame-Locked Clock Prescaler and Power Manager

This block runs in the master-clock domain of a voiceband converter's serial port. The master clock is fixed at 2.000 MHz and the frame sync arrives at 8 kHz, so one frame holds 250 master-clock cycles. Neither 256 kHz nor 512 kHz divides 2.000 MHz evenly. The block therefore uses phase accumulators that restart on every rising edge of frame sync. They produce exactly 32 (or 64) single-cycle strobes per frame, and the sample-rate strobe follows each frame-sync rise. Frame sync is sampled on the rising master-clock edge. The rising edge is detected against a registered copy of frame sync.

The block also measures the period between frame-sync rises to report lock. It watches for a frame sync that has gone missing, which puts the block into standby. It obeys a power-up pin, which forces power-down when low. After standby or power-down, the block grants the serial output permission to drive only once two full frames have passed since the first frame-sync rise. While the block is in standby or powered down, all strobes are held low.

Top module: `fs_clock_manager`

## Requirements
- R1: After reset the block is in standby, with the 8 kHz, 256 kHz and 512 kHz strobes low, lock low, power-down low and the output-enable permission low.
- R2: While running (wake-up or active state), the 8 kHz strobe is a one-cycle pulse asserted in the cycle after each cycle in which frame sync is high following a low cycle.
- R3: While running, the 256 kHz strobe is high in the j-th cycle after a frame-sync rise strobe (j = 0 being the 8 kHz strobe cycle) exactly when floor(32(j+1)/250) differs from floor(32j/250). This gives exactly 32 strobes in a 250-cycle frame, never in two adjacent cycles.
- R4: The 512 kHz strobe follows the same rule with 64 in place of 32, giving 64 strobes per 250-cycle frame.
- R5: Every frame-sync rise restarts the strobe phase, including when frames are shorter or longer than 250 cycles.
- R6: Lock goes high after two consecutive measured periods of 249 to 251 cycles. A period outside that window, a missing frame or a low power-up pin clears it.
- R7: If 256 cycles follow a frame-sync rise with no new rise, the block enters standby in the next cycle and clears lock. A period of exactly 256 cycles is accepted.
- R8: When the power-up pin is low, the block is in power-down from the next cycle, with strobes and output permission low. When the pin returns high, the block moves to standby.
- R9: From standby, the first frame-sync rise starts wake-up. The output-enable permission rises together with the 8 kHz strobe of the third rise, so two full frames pass with the output held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2.000 MHz master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync_i | input | 1 | 8 kHz frame sync, synchronous to clk_i |
| pwr_up_i | input | 1 | Power-up pin; low forces power-down |
| stb_8k_o | output | 1 | Sample-rate strobe |
| stb_256k_o | output | 1 | 256 kHz converter strobe |
| stb_512k_o | output | 1 | 512 kHz converter strobe |
| locked_o | output | 1 | Frame period within tolerance for two frames |
| standby_o | output | 1 | Waiting for frame sync |
| powerdown_o | output | 1 | Forced off by the power-up pin |
| tx_enable_o | output | 1 | Serial output may leave high impedance |

## Verification
The assertions check several rules on every cycle. A low power-up pin forces power-down. A missing frame moves the block to standby and drops lock. Lock and output permission rise only in response to a frame-sync rise. The strobe accumulators stay in range and never strobe in adjacent cycles. Only the bench scenarios can show the rest, by comparing each output on every cycle against an arithmetic model: the exact strobe positions and counts, the restart of phase on short frames, the 256/257-cycle boundary of missing-frame detection, the tolerance window of lock, and the two-frame wake-up delay.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_IDLE = 2'd1,
    PM_WAKE = 2'd2,
    PM_RUN  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/fcm_frame_meter.sv
module fcm_frame_meter #(
  parameter int FRAME_CYC   = 250,
  parameter int LOCK_TOL    = 1,
  parameter int MISS_LIMIT  = 256,
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic clr_i,
  input  logic rise_i,
  output logic miss_o,
  output logic lock_o
);
  localparam int CW = $clog2(MISS_LIMIT + 2);
  localparam int LW = $clog2(LOCK_FRAMES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] good_q, good_d;
  logic          in_win;

  always_comb begin
    in_win = (cnt_q >= CW'(FRAME_CYC - LOCK_TOL)) && (cnt_q <= CW'(FRAME_CYC + LOCK_TOL));
    miss_o = !clr_i && !rise_i && (cnt_q == CW'(MISS_LIMIT));
    cnt_d  = cnt_q;
    good_d = good_q;
    if (clr_i) begin
      cnt_d  = '0;
      good_d = '0;
    end else if (rise_i) begin
      cnt_d = CW'(1);
      if (!in_win)                           good_d = '0;
      else if (good_q != LW'(LOCK_FRAMES))   good_d = good_q + LW'(1);
    end else begin
      if (miss_o)                            good_d = '0;
      if (cnt_q <= CW'(MISS_LIMIT))          cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  assign lock_o = (good_q == LW'(LOCK_FRAMES));

  // R6: lock may only appear as the result of a frame-sync rise
  p_lock_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_o) |-> $past(rise_i));
  // R7: a missing frame removes lock
  p_miss_drops_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    miss_o |=> !lock_o);
endmodule

// File: rtl/fcm_rate_gen.sv
module fcm_rate_gen #(
  parameter int MOD = 250,
  parameter int INC = 32
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic rise_i,
  output logic stb_o
);
  localparam int AW = $clog2(MOD);

  logic [AW-1:0] acc_q, acc_d;
  logic [AW:0]   sum;
  logic          wrap;

  always_comb begin
    sum   = {1'b0, acc_q} + (AW+1)'(INC);
    wrap  = 1'b0;
    acc_d = acc_q;
    if (rise_i) begin
      acc_d = AW'(INC);
    end else if (sum >= (AW+1)'(MOD)) begin
      acc_d = AW'(sum - (AW+1)'(MOD));
      wrap  = 1'b1;
    end else begin
      acc_d = AW'(sum);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_o <= 1'b0;
    end else begin
      acc_q <= acc_d;
      stb_o <= wrap;
    end
  end

  // R5: phase stays inside one modulus
  p_acc_range_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc_q < AW'(MOD));

  if (2 * INC <= MOD) begin : g_gap
    // R3, R4: strobes are isolated single cycles
    p_no_adjacent_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      stb_o |=> !stb_o);
  end
endmodule

// File: rtl/fcm_power_ctrl.sv
module fcm_power_ctrl
  import fcm_pkg::*;
#(
  parameter int WAKE_FRAMES = 2
) (
  input  logic      clk_i,
  input  logic      rst_n,
  input  logic      pwr_up_i,
  input  logic      rise_i,
  input  logic      miss_i,
  output pm_state_e state_o
);
  localparam int WW = $clog2(WAKE_FRAMES + 1);

  pm_state_e     state_q, state_d;
  logic [WW-1:0] wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    if (!pwr_up_i) begin
      state_d = PM_OFF;
    end else begin
      unique case (state_q)
        PM_OFF:  state_d = PM_IDLE;
        PM_IDLE: if (rise_i) begin
                   state_d = PM_WAKE;
                   wake_d  = '0;
                 end
        PM_WAKE: if (miss_i) begin
                   state_d = PM_IDLE;
                 end else if (rise_i) begin
                   if (wake_q == WW'(WAKE_FRAMES - 1)) state_d = PM_RUN;
                   else                                wake_d  = wake_q + WW'(1);
                 end
        PM_RUN:  if (miss_i) state_d = PM_IDLE;
        default: state_d = PM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_IDLE;
      wake_q  <= '0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign state_o = state_q;

  // R8: a low power-up pin forces power-down
  p_pin_low_off_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pwr_up_i |=> state_q == PM_OFF);
  // R7: a missing frame with the pin high leads to standby
  p_miss_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (miss_i && pwr_up_i) |=> state_q == PM_IDLE);
  // R9: permission is granted only from wake-up, on a frame-sync rise
  p_run_from_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == PM_RUN && $past(state_q) != PM_RUN) |->
      ($past(rise_i) && $past(state_q) == PM_WAKE));
endmodule

// File: rtl/fs_clock_manager.sv
module fs_clock_manager
  import fcm_pkg::*;
#(
  parameter int FRAME_CYC   = 250,
  parameter int FAST_STB    = 32,
  parameter int MISS_LIMIT  = 256,
  parameter int LOCK_TOL    = 1,
  parameter int LOCK_FRAMES = 2,
  parameter int WAKE_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic pwr_up_i,
  output logic stb_8k_o,
  output logic stb_256k_o,
  output logic stb_512k_o,
  output logic locked_o,
  output logic standby_o,
  output logic powerdown_o,
  output logic tx_enable_o
);
  localparam int NRATE = 2;

  logic [1:0]       rsync_q;
  logic             rst_n;
  logic             fs_q;
  logic             rise;
  logic             miss;
  logic             stb8_q;
  logic             running;
  logic [NRATE-1:0] stb_raw;
  pm_state_e        pm_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      stb8_q <= 1'b0;
    end else begin
      fs_q   <= fsync_i;
      stb8_q <= rise;
    end
  end
  assign rise = fsync_i && !fs_q;

  fcm_frame_meter #(
    .FRAME_CYC(FRAME_CYC), .LOCK_TOL(LOCK_TOL),
    .MISS_LIMIT(MISS_LIMIT), .LOCK_FRAMES(LOCK_FRAMES)
  ) u_meter (
    .clk_i(clk_i), .rst_n(rst_n), .clr_i(!pwr_up_i), .rise_i(rise),
    .miss_o(miss), .lock_o(locked_o)
  );

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    fcm_rate_gen #(.MOD(FRAME_CYC), .INC(FAST_STB << g)) u_rate (
      .clk_i(clk_i), .rst_n(rst_n), .rise_i(rise), .stb_o(stb_raw[g])
    );
  end

  fcm_power_ctrl #(.WAKE_FRAMES(WAKE_FRAMES)) u_power (
    .clk_i(clk_i), .rst_n(rst_n), .pwr_up_i(pwr_up_i), .rise_i(rise),
    .miss_i(miss), .state_o(pm_state)
  );

  assign running     = (pm_state == PM_WAKE) || (pm_state == PM_RUN);
  assign stb_8k_o    = running && stb8_q;
  assign stb_256k_o  = running && stb_raw[0];
  assign stb_512k_o  = running && stb_raw[1];
  assign standby_o   = (pm_state == PM_IDLE);
  assign powerdown_o = (pm_state == PM_OFF);
  assign tx_enable_o = (pm_state == PM_RUN);

  // R2: the sample strobe follows a frame-sync rise by one cycle
  p_8k_after_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    stb_8k_o |-> $past(rise));
endmodule

// File: tb/fs_clock_manager_bench.sv
module fs_clock_manager_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic pwr_up = 1'b1;
  logic stb_8k, stb_256k, stb_512k, locked, standby, powerdown, tx_en;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_good = 0, m_st = 1, m_wake = 0, m_j = 0;
  bit m_fsq = 1'b0;
  bit e8 = 0, e256 = 0, e512 = 0, elk = 0, esb = 1, epd = 0, etx = 0;

  always #2 clk = ~clk;

  fs_clock_manager u_fs_clock_manager (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .pwr_up_i(pwr_up),
    .stb_8k_o(stb_8k), .stb_256k_o(stb_256k), .stb_512k_o(stb_512k),
    .locked_o(locked), .standby_o(standby), .powerdown_o(powerdown),
    .tx_enable_o(tx_en)
  );

  task automatic chk(input logic act, input bit exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit fs, input bit pu);
    bit rise, miss;
    rise = fs && !m_fsq;
    m_fsq = fs;
    miss = pu && !rise && (m_cnt == 256);
    if (!pu) begin
      m_cnt = 0; m_good = 0;
    end else if (rise) begin
      m_good = (m_cnt >= 249 && m_cnt <= 251) ? ((m_good == 2) ? 2 : m_good + 1) : 0;
      m_cnt = 1;
    end else begin
      if (miss) m_good = 0;
      if (m_cnt <= 256) m_cnt++;
    end
    if (!pu) m_st = 0;
    else begin
      case (m_st)
        0: m_st = 1;
        1: if (rise) begin m_st = 2; m_wake = 0; end
        2: if (miss) m_st = 1;
           else if (rise) begin
             if (m_wake == 1) m_st = 3; else m_wake++;
           end
        default: if (miss) m_st = 1;
      endcase
    end
    if (rise) m_j = 0; else m_j++;
    e8   = (m_st >= 2) && rise;
    e256 = (m_st >= 2) && ((32 * (m_j + 1)) / 250 != (32 * m_j) / 250);
    e512 = (m_st >= 2) && ((64 * (m_j + 1)) / 250 != (64 * m_j) / 250);
    elk  = (m_good == 2);
    esb  = (m_st == 1);
    epd  = (m_st == 0);
    etx  = (m_st == 3);
  endtask

  // called at a falling edge: check outputs, drive the next cycle's inputs
  task automatic step(input bit fs);
    chk(stb_8k,   e8,   "R2 8k strobe");
    chk(stb_256k, e256, "R3 R5 256k strobe");
    chk(stb_512k, e512, "R4 R5 512k strobe");
    chk(locked,   elk,  "R6 lock");
    chk(standby,  esb,  "R7 standby");
    chk(powerdown, epd, "R8 powerdown");
    chk(tx_en,    etx,  "R9 output enable");
    fsync = fs;
    model(fs, pwr_up);
    @(negedge clk);
  endtask

  task automatic frame(input int per, input int hi);
    for (int i = 0; i < per; i++) step(i < hi);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R1: reset state
    chk(standby, 1'b1, "R1 standby after reset");
    chk(tx_en, 1'b0, "R1 output enable after reset");
    chk(locked, 1'b0, "R1 lock after reset");
    chk(powerdown, 1'b0, "R1 powerdown after reset");
    chk(stb_256k | stb_512k | stb_8k, 1'b0, "R1 strobes after reset");
    frame(7, 0);
    // nominal frames: wake-up, lock, activation (R2 R3 R4 R6 R9)
    for (int f = 0; f < 7; f++) frame(250, 1);
    // long pulses still give one rise per frame
    for (int f = 0; f < 3; f++) frame(250, 120);
    // tolerance window, then a period outside it (R6)
    frame(251, 1); frame(249, 1); frame(251, 1); frame(245, 1);
    for (int f = 0; f < 3; f++) frame(250, 1);
    // short frames restart the phase (R5)
    for (int f = 0; f < 3; f++) frame(200, 1);
    for (int f = 0; f < 3; f++) frame(250, 1);
    // missing-frame boundary: 256 accepted, 257 is missing (R7)
    frame(256, 1); frame(257, 1);
    for (int f = 0; f < 5; f++) frame(250, 1);
    // long silence, then recovery (R7 R9)
    frame(600, 0);
    for (int f = 0; f < 5; f++) frame(250, 1);
    // power pin low with frames present, then high again (R8)
    pwr_up = 1'b0;
    frame(250, 1); frame(250, 1);
    pwr_up = 1'b1;
    for (int f = 0; f < 5; f++) frame(250, 1);
    frame(5, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule